// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Channel

This block is one asynchronous transmit channel. A processor-side write hands it a byte; the byte goes either straight into the serial shift register or, when a character is already on the line, waits in a single holding register. The shift register sends a frame made of a low start bit, the data bits least significant bit first, and one or more high stop bits. Each bit takes one pulse of a bit-rate enable input supplied from outside.

The moment a character ends is the one point where the channel decides what happens next. If the transmitter is enabled, no break is requested and a byte is waiting, that byte follows with no gap. If a break is requested, the line is held low. Otherwise the line rests high. Two status levels and an interrupt pulse report buffer-empty and all-sent to the processor. An RTS output follows its request bit, except that releasing it waits until both the holding register and the shift register have drained.

Top module: `sertx_channel`

## Requirements
- R1: Out of reset, txd is 1, buf_empty is 1, all_sent is 1, irq is 0 and rts_n is 1.
- R2: A frame is one 0 start bit, DATA_W data bits least significant first, then STOP_BITS 1 bits. Each bit holds txd for exactly one bit_tick period. The first bit appears at the first bit_tick after a direct load, or at the same tick that reloads the shifter from the holding register.
- R3: A write while tx_enable is 1 and the shifter is idle loads the byte straight into the shifter and leaves buf_empty at 1. A bit_tick in that same cycle is not used.
- R4: Any other write stores the byte in the holding register and clears buf_empty on the next clock. A second write before the reload replaces the stored byte.
- R5: Every write clears all_sent on the next clock.
- R6: At the bit_tick after the last stop bit began, the holding byte is loaded if tx_enable is 1, send_break is 0 and buf_empty is 0. Its start bit goes out at that tick and buf_empty sets.
- R7: irq is a single-cycle pulse, raised one clock after a direct load or a reload, and only when irq_enable is 1.
- R8: At a free bit_tick (character end or idle) with send_break at 1, txd goes to 0 and any holding byte is kept.
- R9: At a free bit_tick with no byte loaded and send_break at 0, txd goes to 1 (mark).
- R10: all_sent sets at a character end where buf_empty is 1.
- R11: A byte written while tx_enable is 0 waits in the holding register. It starts at the first free bit_tick once tx_enable is 1.
- R12: With rts_request at 1, rts_n is 0 on the next clock. With rts_request at 0, rts_n rises only on the clock after all_sent reads 1, and stays low while all_sent is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Data write strobe, one cycle per byte |
| wr_data | input | DATA_W | Byte written |
| tx_enable | input | 1 | Transmitter enable |
| send_break | input | 1 | Hold the line at 0 when no character is in flight |
| irq_enable | input | 1 | Allow the transmit interrupt pulse |
| rts_request | input | 1 | Request RTS active |
| bit_tick | input | 1 | One pulse per serial bit period |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register has no byte waiting |
| all_sent | output | 1 | Both registers drained since the last write |
| irq | output | 1 | Transmit interrupt pulse |
| rts_n | output | 1 | RTS, active low |

## Verification
The bench builds the channel with DATA_W = 8 and STOP_BITS = 2. The second stop bit shows that the character end comes one tick after the last stop bit starts, not at it. Because bit_tick comes from the bench, runs can use a tick on every clock, every few clocks, or at random. That brings within reach the corner cases where a write lands in the same cycle as a character end, or in the same cycle as an idle tick. Long random runs also toggle enable, break and the RTS request while a frame is in flight.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmit channel.
// Assumes: nothing beyond standard SystemVerilog.
package sertx_pkg;

    // Command given to the shifter for the current cycle.
    typedef enum logic [1:0] {
        SHC_RUN    = 2'd0,  // shift on bit_tick if bits remain
        SHC_DIRECT = 2'd1,  // load a written byte, first bit at next tick
        SHC_RELOAD = 2'd2,  // load holding byte and send start bit now
        SHC_PARK   = 2'd3   // free tick with nothing to load: drive park level
    } sh_cmd_e;

endpackage

// File: rtl/sertx_holding.sv
// Holding register and buffer-empty flag.
// Assumes: direct and reload are never both high; a write takes priority
// over a reload for the flag, so a reload in the same cycle uses the old byte.
module sertx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              direct,
    input  logic              reload,
    output logic [DATA_W-1:0] hold_q,
    output logic              buf_empty
);

    // Store written bytes and track whether one is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            buf_empty <= 1'b1;
        end else if (wr_en) begin
            hold_q    <= wr_data;
            buf_empty <= direct;
        end else if (reload) begin
            buf_empty <= 1'b1;
        end
    end

    // R4: the flag only drops after a write
    a_r4_empty_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(wr_en));

    // R6: a reload with no write leaves the buffer empty
    a_r6_reload_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_en) |=> buf_empty);

endmodule

// File: rtl/sertx_shifter.sv
// Serial shift register with frame construction and line driver.
// Assumes: cmd is decided by the parent from the free-slot state reported here;
// free_slot is high whenever no bit remains to be started.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int STOP_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sh_cmd_e           cmd,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] load_data,
    input  logic              park_level,
    output logic              line,
    output logic              active,
    output logic              free_slot
);

    localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;

    // Assemble the frame: start bit at bit 0, stop bits at the top.
    always_comb begin
        frame = {{STOP_BITS{1'b1}}, load_data, 1'b0};
    end

    assign free_slot = (left == '0);

    // Load frames, shift one bit per tick and drive the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            left   <= '0;
            line   <= 1'b1;
            active <= 1'b0;
        end else begin
            case (cmd)
                SHC_DIRECT: begin
                    shreg  <= frame;
                    left   <= CNT_FULL;
                    active <= 1'b1;
                end
                SHC_RELOAD: begin
                    shreg  <= {1'b1, frame[FRAME_W-1:1]};
                    line   <= frame[0];
                    left   <= CNT_FULL - 1'b1;
                    active <= 1'b1;
                end
                SHC_PARK: begin
                    line   <= park_level;
                    active <= 1'b0;
                end
                default: begin
                    if (bit_tick && !free_slot) begin
                        line  <= shreg[0];
                        shreg <= {1'b1, shreg[FRAME_W-1:1]};
                        left  <= left - 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: bit counter never exceeds a frame
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        left <= CNT_FULL);

    // R2: an idle shifter has no bits pending
    a_r2_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> free_slot);

    // R2: a reload puts the start bit on the line
    a_r2_reload_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SHC_RELOAD) |=> !line);

endmodule

// File: rtl/sertx_status.sv
// All-sent flag, RTS output with deferred release, and interrupt pulse.
// Assumes: drained_end is high for one cycle at a character end with an
// empty holding register; load_evt marks a direct load or reload.
module sertx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic drained_end,
    input  logic load_evt,
    input  logic irq_enable,
    input  logic rts_request,
    output logic all_sent,
    output logic rts_n,
    output logic irq
);

    // Track whether everything written has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n)          all_sent <= 1'b1;
        else if (wr_en)      all_sent <= 1'b0;
        else if (drained_end) all_sent <= 1'b1;
    end

    // Assert RTS on request; release only once drained.
    always_ff @(posedge clk) begin
        if (!rst_n)          rts_n <= 1'b1;
        else if (rts_request) rts_n <= 1'b0;
        else if (all_sent)   rts_n <= 1'b1;
    end

    // Pulse the interrupt for each byte taken by the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= load_evt && irq_enable;
    end

    // R5: a write clears all-sent
    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !all_sent);

    // R12: request drives RTS active
    a_r12_rts_on: assert property (@(posedge clk) disable iff (!rst_n)
        rts_request |=> !rts_n);

    // R12: no release while data is still pending
    a_r12_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && !all_sent) |=> !rts_n);

    // R7: interrupt is never two cycles long
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: rtl/sertx_channel.sv
// Double-buffered asynchronous transmit channel (top).
// Assumes: control inputs are synchronous to clk; bit_tick is a one-cycle
// pulse per bit period. Decides, per cycle, between direct load, reload,
// park and plain shifting, and wires the holding, shifter and status parts.
module sertx_channel
    import sertx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int STOP_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              send_break,
    input  logic              irq_enable,
    input  logic              rts_request,
    input  logic              bit_tick,
    output logic              txd,
    output logic              buf_empty,
    output logic              all_sent,
    output logic              irq,
    output logic              rts_n
);

    logic              sh_active;
    logic              sh_free;
    logic              wr_direct;
    logic              slot;
    logic              reload;
    logic              char_end;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] load_data;
    sh_cmd_e           cmd;

    // Decide what the shifter does this cycle.
    always_comb begin
        wr_direct = wr_en && tx_enable && !sh_active;
        slot      = bit_tick && sh_free && !wr_direct;
        reload    = slot && tx_enable && !send_break && !buf_empty;
        char_end  = slot && sh_active;
        if (wr_direct)   cmd = SHC_DIRECT;
        else if (reload) cmd = SHC_RELOAD;
        else if (slot)   cmd = SHC_PARK;
        else             cmd = SHC_RUN;
        load_data = wr_direct ? wr_data : hold_q;
    end

    sertx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .direct    (wr_direct),
        .reload    (reload),
        .hold_q    (hold_q),
        .buf_empty (buf_empty)
    );

    sertx_shifter #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .bit_tick   (bit_tick),
        .load_data  (load_data),
        .park_level (!send_break),
        .line       (txd),
        .active     (sh_active),
        .free_slot  (sh_free)
    );

    sertx_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .drained_end (char_end && buf_empty),
        .load_evt    (wr_direct || reload),
        .irq_enable  (irq_enable),
        .rts_request (rts_request),
        .all_sent    (all_sent),
        .rts_n       (rts_n),
        .irq         (irq)
    );

    // R3: a direct load keeps the buffer empty
    a_r3_direct_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_enable && !sh_active) |=> buf_empty);

    // R8: break at a free slot drives the line low
    a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && sh_free && !wr_en && send_break) |=> !txd);

    // R9: idle mark at a free slot with nothing to load
    a_r9_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && sh_free && !wr_en && !send_break && (buf_empty || !tx_enable)) |=> txd);

    // R10: an end with empty buffer sets all-sent
    a_r10_drain_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && sh_free && sh_active && buf_empty && !wr_en) |=> all_sent);

endmodule

// File: tb/sertx_channel_tb.sv
// Bench: behavioural reference model (bit queue) compared on every clock.
module sertx_channel_tb;

    localparam int DW = 8;
    localparam int SB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          tx_enable = 1'b0;
    logic          send_break = 1'b0;
    logic          irq_enable = 1'b0;
    logic          rts_request = 1'b0;
    logic          bit_tick = 1'b0;
    logic          txd, buf_empty, all_sent, irq, rts_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sertx_channel #(.DATA_W(DW), .STOP_BITS(SB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .send_break(send_break), .irq_enable(irq_enable),
        .rts_request(rts_request), .bit_tick(bit_tick), .txd(txd),
        .buf_empty(buf_empty), .all_sent(all_sent), .irq(irq), .rts_n(rts_n)
    );

    // ---------------- reference model ----------------
    logic          q[$];
    bit            m_busy;
    logic [DW-1:0] m_hold;
    logic          m_be, m_as, m_irq, m_line, m_rts;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_hold = '0; m_be = 1; m_as = 1; m_irq = 0;
            m_line = 1; m_rts = 1;
        end else begin
            bit direct, slot, ld, fin;
            direct = wr_en && tx_enable && !m_busy;
            slot   = bit_tick && (q.size() == 0) && !direct;
            ld     = slot && tx_enable && !send_break && !m_be;
            fin    = slot && m_busy;
            m_irq  = (direct || ld) && irq_enable;
            if (rts_request) m_rts = 0;
            else if (m_as)   m_rts = 1;
            if (wr_en)              m_as = 0;
            else if (fin && m_be)   m_as = 1;
            if (direct || ld) begin
                logic [DW-1:0] d;
                d = direct ? wr_data : m_hold;
                q.delete();
                q.push_back(1'b0);
                for (int i = 0; i < DW; i++) q.push_back(d[i]);
                for (int i = 0; i < SB; i++) q.push_back(1'b1);
                m_busy = 1;
                if (ld) m_line = q.pop_front();
            end else if (slot) begin
                m_line = !send_break;
                m_busy = 0;
            end else if (bit_tick && q.size() > 0) begin
                m_line = q.pop_front();
            end
            if (wr_en) begin
                m_hold = wr_data;
                m_be   = direct;
            end else if (ld) begin
                m_be = 1;
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    // Compare every output on every clock, away from the active edge.
    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(txd,       m_line, "R2 txd");
            chk(buf_empty, m_be,   "R4 buf_empty");
            chk(all_sent,  m_as,   "R10 all_sent");
            chk(irq,       m_irq,  "R7 irq");
            chk(rts_n,     m_rts,  "R12 rts_n");
        end
    end

    // ---------------- bit tick generator ----------------
    int tick_mode = 0;   // 0 off, 1 every clock, 2 every tick_div, 3 random
    int tick_div  = 3;
    int tick_ctr  = 0;
    always @(negedge clk) begin
        case (tick_mode)
            1: bit_tick = 1'b1;
            2: begin
                tick_ctr = (tick_ctr + 1) % tick_div;
                bit_tick = (tick_ctr == 0);
            end
            3: bit_tick = ($urandom % 3) == 0;
            default: bit_tick = 1'b0;
        endcase
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        idle(3);
        // R1: reset values
        chk(txd, 1'b1, "R1 txd"); chk(buf_empty, 1'b1, "R1 buf_empty");
        chk(all_sent, 1'b1, "R1 all_sent"); chk(irq, 1'b0, "R1 irq");
        chk(rts_n, 1'b1, "R1 rts_n");
        rst_n = 1'b1;
        cmp_on = 1;

        // R3 R2: direct load, slow ticks
        rts_request = 1; tx_enable = 1; irq_enable = 1;
        tick_mode = 2; tick_div = 3;
        write(8'hA5);
        idle(50);

        // R6 R4: back-to-back with overwrite of the holding byte
        tick_mode = 1;
        write(8'h3C); write(8'h11); write(8'hC7);
        idle(40);

        // R11: byte waits while disabled
        tx_enable = 0;
        write(8'h5A);
        idle(20);
        chk(buf_empty, 1'b0, "R11 held while disabled");
        tx_enable = 1;
        idle(30);

        // R8 R9: break during a frame, then release
        write(8'hF0);
        idle(3);
        send_break = 1;
        write(8'h0F);
        idle(20);
        chk(txd, 1'b0, "R8 break level");
        chk(buf_empty, 1'b0, "R8 byte kept during break");
        send_break = 0;
        idle(30);
        chk(txd, 1'b1, "R9 mark after frame");

        // R12: release deferred until drained
        write(8'h81);
        idle(2);
        rts_request = 0;
        idle(2);
        chk(rts_n, 1'b0, "R12 rts held while sending");
        idle(20);
        chk(rts_n, 1'b1, "R12 rts released after drain");

        // R7: no interrupt when disabled; R5 write clears all-sent
        irq_enable = 0;
        write(8'h99);
        chk(all_sent, 1'b0, "R5 write clears all_sent");
        idle(30);

        // random phase
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            wr_en   = ($urandom % 10) == 0;
            wr_data = DW'($urandom);
            if (($urandom % 150) == 0) tx_enable   = ~tx_enable;
            if (($urandom % 250) == 0) send_break  = ~send_break;
            if (($urandom % 80)  == 0) irq_enable  = ~irq_enable;
            if (($urandom % 120) == 0) rts_request = ~rts_request;
            if (($urandom % 400) == 0) tick_mode   = 1 + ($urandom % 3);
        end
        wr_en = 0;
        idle(5);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: got running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule